// File: doc/BRIEF.md
# Scanline-Paced Keyboard Frame Receiver

This block receives scan-code bytes from a PS/2 keyboard without a dedicated oversampling clock. It looks at the keyboard clock and data lines only when an external once-per-scanline strobe fires. Between strobes, a sticky change flag records any transition of the keyboard clock. At each strobe the block takes a snapshot that holds the clock level, the data level and the flag together. It clears the flag only when the snapshot saw it set, and an edge that lands in the same cycle as the clear survives it.

A frame assembler walks through the snapshots. It detects falling edges of the keyboard clock and collects start, data, parity and stop bits. It discards malformed frames, and it drops a partial frame when the keyboard goes quiet for too long. Accepted bytes go unchanged into a small ring buffer. A consumer reads the head byte and pops it with a one-cycle request. A strobe at about twice the keyboard clock rate is enough to see every clock level, for example a 30 kHz line rate against a keyboard clock of up to 15 kHz.

Top module: `kbd_line_sampler`

## Requirements
- R1: After synchronous reset, `out_count` is 0, `out_valid` is 0 and `overflow` is 0.
- R2: The keyboard lines are looked at only in cycles where `line_strobe` is high. A low pulse on the keyboard clock that starts and ends between two strobes contributes no bit.
- R3: Any change of `kclk_sync` from one cycle to the next sets the internal change flag on the following cycle. The flag stays set until a strobe clears it.
- R4: A strobe clears the change flag only when the flag was set in that cycle. A keyboard clock edge arriving in that same cycle leaves the flag set.
- R5: A bit is taken on a falling edge. The snapshot must show the clock low and the change flag set, and the previous snapshot must show the clock high. The data level of that snapshot is the bit.
- R6: A frame is 11 bits: a start bit of 0, then 8 data bits with bit 0 first, then an odd parity bit (the 9 bits of data and parity contain an odd number of ones), then a stop bit of 1. A correct frame pushes its data byte into the buffer.
- R7: A frame with a wrong parity bit or a stop bit of 0 pushes nothing. A falling edge with data high while idle is not taken as a start bit.
- R8: If more than `TIMEOUT` (default 64) strobes pass without a falling edge during a partial frame, the partial frame is dropped and the next falling edge with data low starts a new frame. A gap of 64 strobes or fewer does not interrupt a frame.
- R9: The buffer holds `DEPTH` (default 16) bytes and gives them out in arrival order. `out_valid` is high when `out_count` is non-zero. `pop_req` with `out_valid` high removes the head. A byte arriving while the buffer is full is dropped, even with a pop in the same cycle, and `overflow` is set and stays set until reset.
- R10: Bytes are stored untranslated, so a key release appears as F0 followed by the key's code, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kclk_sync | input | 1 | Keyboard clock line, already synchronised |
| kdat_sync | input | 1 | Keyboard data line, already synchronised |
| line_strobe | input | 1 | One-cycle pulse once per scanline |
| pop_req | input | 1 | Remove the head byte of the buffer |
| out_byte | output | 8 | Head byte of the buffer |
| out_valid | output | 1 | Buffer is not empty |
| out_count | output | $clog2(DEPTH+1) | Number of bytes held |
| overflow | output | 1 | Sticky flag: a byte was dropped because the buffer was full |

## Verification
The bench builds the block with the default `DEPTH` of 16 and `TIMEOUT` of 64. Sixteen bytes keep the full buffer and the sticky overflow within a few hundred strobes. A 64-strobe window lets the bench test both sides of the timeout: an in-frame gap of 50 strobes must be tolerated, and a gap of 70 strobes must drop the partial frame. Varying the strobes per keyboard half-period between one and three exercises the slowest and fastest keyboard clocks the strobe rate can follow.

// File: rtl/kls_pkg.sv
package kls_pkg;

    typedef struct packed {
        logic kclk;
        logic kdat;
        logic chg;
    } line_snap_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    function automatic logic odd_parity_ok(input logic [7:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/kls_edge_flag.sv
module kls_edge_flag (
    input  logic clk,
    input  logic rst,
    input  logic kclk_sync,
    input  logic strobe,
    output logic chg_flag
);
    logic prev_kclk;
    logic edge_now;
    logic clr;

    assign edge_now = kclk_sync ^ prev_kclk;
    // clear only a flag that this strobe actually observed
    assign clr = strobe & chg_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_kclk <= kclk_sync;
            chg_flag  <= 1'b0;
        end else begin
            prev_kclk <= kclk_sync;
            // a same-cycle edge wins over the clear
            chg_flag  <= (chg_flag & ~clr) | edge_now;
        end
    end
endmodule

// File: rtl/kls_frame_rx.sv
module kls_frame_rx
    import kls_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       snap_vld,
    input  line_snap_t snap,
    output logic       push,
    output logic [7:0] push_byte
);
    localparam int TW = $clog2(TIMEOUT + 2);

    rx_state_t       state;
    logic [7:0]      shreg;
    logic [2:0]      nbit;
    logic            par;
    logic            prev_level;
    logic [TW-1:0]   idle_cnt;
    logic            fall;

    assign fall = snap_vld & snap.chg & prev_level & ~snap.kclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            shreg      <= '0;
            nbit       <= '0;
            par        <= 1'b0;
            prev_level <= 1'b1;
            idle_cnt   <= '0;
            push       <= 1'b0;
            push_byte  <= '0;
        end else begin
            push <= 1'b0;
            if (snap_vld) begin
                prev_level <= snap.kclk;
                if (fall) begin
                    idle_cnt <= '0;
                    unique case (state)
                        RX_IDLE: begin
                            if (!snap.kdat) begin
                                state <= RX_DATA;
                                nbit  <= '0;
                            end
                        end
                        RX_DATA: begin
                            shreg <= {snap.kdat, shreg[7:1]};
                            nbit  <= nbit + 3'd1;
                            if (nbit == 3'd7) state <= RX_PAR;
                        end
                        RX_PAR: begin
                            par   <= snap.kdat;
                            state <= RX_STOP;
                        end
                        RX_STOP: begin
                            if (snap.kdat && odd_parity_ok(shreg, par)) begin
                                push      <= 1'b1;
                                push_byte <= shreg;
                            end
                            state <= RX_IDLE;
                        end
                        default: state <= RX_IDLE;
                    endcase
                end else if (state != RX_IDLE) begin
                    if (idle_cnt == TW'(TIMEOUT)) begin
                        state    <= RX_IDLE;
                        idle_cnt <= '0;
                    end else begin
                        idle_cnt <= idle_cnt + TW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/kls_ring.sv
module kls_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               push_byte,
    input  logic                       pop_req,
    output logic [W-1:0]               out_byte,
    output logic                       out_valid,
    output logic [$clog2(DEPTH+1)-1:0] out_count,
    output logic                       overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign full      = (out_count == CW'(DEPTH));
    assign out_valid = (out_count != '0);
    assign do_push   = push & ~full;
    assign do_pop    = pop_req & out_valid;
    assign out_byte  = mem[rd_ptr];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            out_count <= '0;
            overflow  <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            if (do_push && !do_pop)      out_count <= out_count + CW'(1);
            else if (do_pop && !do_push) out_count <= out_count - CW'(1);
            if (push && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/kbd_line_sampler.sv
module kbd_line_sampler
    import kls_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TIMEOUT = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       kclk_sync,
    input  logic                       kdat_sync,
    input  logic                       line_strobe,
    input  logic                       pop_req,
    output logic [7:0]                 out_byte,
    output logic                       out_valid,
    output logic [$clog2(DEPTH+1)-1:0] out_count,
    output logic                       overflow
);
    logic       chg_flag;
    line_snap_t snap_q;
    logic       snap_vld;
    logic       push;
    logic [7:0] push_byte;

    kls_edge_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .kclk_sync(kclk_sync),
        .strobe   (line_strobe),
        .chg_flag (chg_flag)
    );

    // one snapshot per scanline, all three fields taken together
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_vld <= 1'b0;
            snap_q   <= '{kclk: 1'b1, kdat: 1'b1, chg: 1'b0};
        end else begin
            snap_vld <= line_strobe;
            if (line_strobe) snap_q <= '{kclk: kclk_sync, kdat: kdat_sync, chg: chg_flag};
        end
    end

    kls_frame_rx #(.TIMEOUT(TIMEOUT)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .snap_vld (snap_vld),
        .snap     (snap_q),
        .push     (push),
        .push_byte(push_byte)
    );

    kls_ring #(.DEPTH(DEPTH), .W(8)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_byte(push_byte),
        .pop_req  (pop_req),
        .out_byte (out_byte),
        .out_valid(out_valid),
        .out_count(out_count),
        .overflow (overflow)
    );
endmodule

// File: rtl/kls_checks.sv
module kls_checks #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       kclk_sync,
    input logic                       line_strobe,
    input logic                       chg_flag,
    input logic                       push,
    input logic                       pop_req,
    input logic                       out_valid,
    input logic [$clog2(DEPTH+1)-1:0] out_count,
    input logic                       overflow
);
    localparam int CW = $clog2(DEPTH + 1);

    a_r1_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> (out_count == '0 && !overflow));

    a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (kclk_sync != $past(kclk_sync)) |=> chg_flag);

    a_r4_seen_flag_cleared: assert property (@(posedge clk) disable iff (rst)
        (line_strobe && chg_flag && $stable(kclk_sync)) |=> !chg_flag);

    a_r4_unseen_flag_kept: assert property (@(posedge clk) disable iff (rst)
        (!line_strobe && chg_flag) |=> chg_flag);

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        out_count <= CW'(DEPTH));

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r9_pop_decrements: assert property (@(posedge clk) disable iff (rst)
        (pop_req && out_valid && !push) |=> (out_count == $past(out_count) - CW'(1)));
endmodule

bind kbd_line_sampler kls_checks #(.DEPTH(DEPTH)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .kclk_sync  (kclk_sync),
    .line_strobe(line_strobe),
    .chg_flag   (chg_flag),
    .push       (push),
    .pop_req    (pop_req),
    .out_valid  (out_valid),
    .out_count  (out_count),
    .overflow   (overflow)
);

// File: tb/kbd_line_sampler_bench.sv
module kbd_line_sampler_bench;
    localparam int DEPTH   = 16;
    localparam int TIMEOUT = 64;
    localparam int CW      = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          kclk_sync = 1'b1;
    logic          kdat_sync = 1'b1;
    logic          line_strobe = 1'b0;
    logic          pop_req = 1'b0;
    logic [7:0]    out_byte;
    logic          out_valid;
    logic [CW-1:0] out_count;
    logic          overflow;

    int vectors = 0;
    int fails   = 0;
    logic [7:0] model [$];

    always #2 clk = ~clk;

    kbd_line_sampler #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) u_kbd_line_sampler (
        .clk(clk), .rst(rst), .kclk_sync(kclk_sync), .kdat_sync(kdat_sync),
        .line_strobe(line_strobe), .pop_req(pop_req), .out_byte(out_byte),
        .out_valid(out_valid), .out_count(out_count), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d);
        return ~(^d);
    endfunction

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) line_strobe = 1'b1;
            @(negedge clk) line_strobe = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_bit(input logic b, input int hp);
        @(negedge clk) kdat_sync = b;
        strobes(hp);
        @(negedge clk) kclk_sync = 1'b0;
        strobes(hp);
        @(negedge clk) kclk_sync = 1'b1;
    endtask

    // kind: 0 good, 1 parity flipped, 2 stop low
    task automatic send_frame(input logic [7:0] d, input int kind, input int hp,
                              input int gap_bit, input int gap_len);
        logic [10:0] bits;
        bits = {(kind == 2) ? 1'b0 : 1'b1, par_of(d) ^ (kind == 1), d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            send_bit(bits[i], hp);
            if (i == gap_bit) strobes(gap_len);
        end
        @(negedge clk) kdat_sync = 1'b1;
        strobes(2);
        if (kind == 0) model.push_back(d);
    endtask

    task automatic pop_one(input string req, input logic [7:0] exp);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " byte"}, int'(out_byte), int'(exp));
        @(negedge clk) pop_req = 1'b1;
        @(negedge clk) pop_req = 1'b0;
    endtask

    task automatic drain(input string req);
        chk({req, " count"}, int'(out_count), model.size());
        while (model.size() > 0) pop_one(req, model.pop_front());
        chk({req, " empty"}, int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0B1E));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", int'(out_count), 0);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 overflow", int'(overflow), 0);

        // R5 R6 bit order: single-bit bytes at both ends
        send_frame(8'h01, 0, 1, -1, 0);
        send_frame(8'h80, 0, 2, -1, 0);
        drain("R6 lsb-first");

        // R10 break sequence in order
        send_frame(8'hF0, 0, 2, -1, 0);
        send_frame(8'h1C, 0, 1, -1, 0);
        drain("R10 break order");

        // R7 bad parity, bad stop, start with data high
        send_frame(8'h33, 1, 2, -1, 0);
        chk("R7 parity dropped", int'(out_count), 0);
        send_frame(8'h44, 2, 2, -1, 0);
        chk("R7 stop dropped", int'(out_count), 0);
        send_bit(1'b1, 2);
        strobes(2);
        send_frame(8'h5A, 0, 2, -1, 0);
        drain("R7 bad start ignored");

        // R2 clock glitch entirely between strobes
        @(negedge clk) kdat_sync = 1'b0;
        @(negedge clk) kclk_sync = 1'b0;
        @(negedge clk) kclk_sync = 1'b1;
        @(negedge clk) kdat_sync = 1'b1;
        strobes(3);
        send_frame(8'hA7, 0, 1, -1, 0);
        drain("R2 glitch unseen");

        // R8 tolerated gap, then timeout
        send_frame(8'h3C, 0, 1, 4, 50);
        drain("R8 gap kept");
        send_bit(1'b0, 2);
        send_bit(1'b1, 2);
        send_bit(1'b1, 2);
        strobes(TIMEOUT + 6);
        send_frame(8'h29, 0, 2, -1, 0);
        drain("R8 timeout restart");

        // R6 R7 R9 random frames
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d;
            int kind, hp;
            d    = 8'($urandom_range(0, 255));
            kind = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 2)) : 0;
            hp   = int'($urandom_range(1, 3));
            send_frame(d, kind, hp, -1, 0);
            chk("R9 count tracks", int'(out_count), model.size());
            if (model.size() >= 6) drain("R6 random");
        end
        drain("R6 random tail");
        chk("R9 no overflow yet", int'(overflow), 0);

        // R9 full buffer, drop and sticky overflow
        for (int n = 0; n < DEPTH + 2; n++) begin
            send_frame(8'(n + 8'h40), 0, 1, -1, 0);
        end
        chk("R9 full count", int'(out_count), DEPTH);
        chk("R9 overflow set", int'(overflow), 1);
        for (int n = 0; n < DEPTH; n++) pop_one("R9 full order", 8'(n + 8'h40));
        chk("R9 drained", int'(out_count), 0);
        chk("R9 overflow sticky", int'(overflow), 1);
        @(negedge clk) pop_req = 1'b1;
        @(negedge clk) pop_req = 1'b0;
        chk("R9 pop on empty", int'(out_count), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule